// File: doc/BRIEF.md
# BCD Alarm-Time Setter

This block keeps a 24-hour alarm time as a packed BCD word (HH:MM) and moves it one minute up or down on each pulse of a slow step strobe, while a two-bit adjust control is held. The strobe comes from an external prescaler, typically at a few hertz. A held control therefore scrolls the time at a rate the user can see. Minute steps use per-digit carry and borrow. The value wraps at the day boundary in both directions, so it always stays a legal time of day.

The block also compares the running time of day, given in the same BCD layout, against the alarm time. A three-state ring machine drives the alarm output from that comparison. The states are RING_OFF, RING_WATCH and RING_ACTIVE, and the machine re-evaluates on every clock. When the arm input is low, the next state is RING_OFF. When arm is high and the two times differ, the next state is RING_WATCH. When arm is high and the two times are equal, the next state is RING_ACTIVE. These three transitions apply from every state. The alarm output is high only in RING_ACTIVE.

Top module: `alarm_time_setter`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) makes alarm_time 16'h0000 and alarm_on low after that edge.
- R2: alarm_time is packed BCD with [15:12] hour tens, [11:8] hour units, [7:4] minute tens and [3:0] minute units. After reset and every step, hour tens ≤ 2, minute tens ≤ 5, the other digits ≤ 9, and the hour field ≤ 23.
- R3: At an edge with step_stb high and adj_ctl = 2'b10, alarm_time advances by one minute. A minute units of 9 becomes 0 and carries into minute tens. A minute tens of 5 becomes 0 and carries into hour units. An hour units of 9 becomes 0 and carries into hour tens.
- R4: At an edge with step_stb high and adj_ctl = 2'b11, alarm_time goes back by one minute. A minute units borrow gives 9, a minute tens borrow gives 5, and an hour units borrow gives 9.
- R5: alarm_time is unchanged at any edge where step_stb is low, or where adj_ctl is 2'b00 or 2'b01.
- R6: Stepping up from 23:59 (16'h2359) gives 00:00 (16'h0000).
- R7: Stepping down from 00:00 gives 23:59 (16'h2359).
- R8: After each non-reset edge, alarm_on is high exactly when, at that edge, arm was high and now_time equalled the alarm_time held before the edge. This is the RING_ACTIVE state; arm low leads to RING_OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_stb | input | 1 | Single-cycle step enable from a prescaler |
| adj_ctl | input | 2 | 2'b10 step up, 2'b11 step down, otherwise hold |
| arm | input | 1 | Alarm arm switch |
| now_time | input | 16 | Running time of day, packed BCD HH:MM |
| alarm_time | output | 16 | Registered alarm time, packed BCD HH:MM |
| alarm_on | output | 1 | Alarm indicator, high in RING_ACTIVE |

## Verification
A wrong digit in the stepping chain appears on alarm_time one clock after the strobe edge that caused it. The fault then stays visible until a later step overwrites it. A bad carry or borrow shows up only at the boundaries: x9, x5x, 09/19 hours and the 23:59/00:00 wrap. For this reason the long directed runs cross every one of them. A ring-machine fault appears on alarm_on one clock after the arm and match inputs change. The bench therefore compares alarm_on on every cycle, and it drives now_time to equal the alarm time often.

// File: rtl/alarm_time_pkg.sv
package alarm_time_pkg;

    localparam int DIGIT_W  = 4;
    localparam int N_DIGITS = 4;
    localparam int WORD_W   = DIGIT_W * N_DIGITS;

    // Digit order inside the word, lowest first.
    localparam int IDX_MIN_UNITS  = 0;
    localparam int IDX_MIN_TENS   = 1;
    localparam int IDX_HOUR_UNITS = 2;
    localparam int IDX_HOUR_TENS  = 3;

    localparam logic [WORD_W-1:0] TIME_ZERO = 16'h0000;
    localparam logic [WORD_W-1:0] TIME_LAST = 16'h2359;
    localparam logic [2*DIGIT_W-1:0] HOUR_LAST = 8'h23;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_UP   = 2'd1,
        CMD_DOWN = 2'd2
    } step_cmd_e;

    typedef enum logic [1:0] {
        RING_OFF    = 2'd0,
        RING_WATCH  = 2'd1,
        RING_ACTIVE = 2'd2
    } ring_state_e;

    // Largest value a digit position may hold before it wraps.
    function automatic logic [DIGIT_W-1:0] digit_limit(input int idx);
        case (idx)
            IDX_MIN_TENS:  digit_limit = DIGIT_W'(5);
            IDX_HOUR_TENS: digit_limit = DIGIT_W'(2);
            default:       digit_limit = DIGIT_W'(9);
        endcase
    endfunction

    function automatic step_cmd_e decode_cmd(input logic stb, input logic [1:0] adj);
        if (!stb || !adj[1])
            decode_cmd = CMD_HOLD;
        else if (adj[0])
            decode_cmd = CMD_DOWN;
        else
            decode_cmd = CMD_UP;
    endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell #(
    parameter int                  DW    = 4,
    parameter logic [DW-1:0]       LIMIT = 4'd9
) (
    input  logic [DW-1:0] d,
    input  logic          up,
    input  logic          ci,
    output logic [DW-1:0] q,
    output logic          co
);
    localparam logic [DW-1:0] ONE  = DW'(1);
    localparam logic [DW-1:0] ZERO = '0;

    always_comb begin
        q  = d;
        co = 1'b0;
        if (ci) begin
            if (up) begin
                if (d >= LIMIT) begin
                    q  = ZERO;
                    co = 1'b1;
                end else begin
                    q = d + ONE;
                end
            end else begin
                if (d == ZERO) begin
                    q  = LIMIT;
                    co = 1'b1;
                end else begin
                    q = d - ONE;
                end
            end
        end
    end
endmodule

// File: rtl/bcd_minute_stepper.sv
module bcd_minute_stepper
    import alarm_time_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  step_cmd_e         cmd,
    output logic [WORD_W-1:0] nxt
);
    logic [N_DIGITS:0]        chain;
    logic [WORD_W-1:0]        raw;
    logic                     going_up;

    assign going_up = (cmd == CMD_UP);
    assign chain[0] = (cmd != CMD_HOLD);

    for (genvar g = 0; g < N_DIGITS; g++) begin : g_digit
        bcd_digit_cell #(
            .DW    (DIGIT_W),
            .LIMIT (digit_limit(g))
        ) i_cell (
            .d  (cur[g*DIGIT_W +: DIGIT_W]),
            .up (going_up),
            .ci (chain[g]),
            .q  (raw[g*DIGIT_W +: DIGIT_W]),
            .co (chain[g+1])
        );
    end

    // Day-boundary fix-ups: an hour past 23 after a step up restarts at
    // midnight, any value past 23:59 after a step down lands on 23:59.
    always_comb begin
        nxt = raw;
        unique case (cmd)
            CMD_UP:   if (raw[WORD_W-1 -: 2*DIGIT_W] > HOUR_LAST) nxt = TIME_ZERO;
            CMD_DOWN: if (raw > TIME_LAST) nxt = TIME_LAST;
            CMD_HOLD: nxt = cur;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/alarm_ring_fsm.sv
module alarm_ring_fsm
    import alarm_time_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic match,
    output logic ring
);
    ring_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RING_OFF,
            RING_WATCH,
            RING_ACTIVE: begin
                if (!arm)
                    state_d = RING_OFF;
                else if (match)
                    state_d = RING_ACTIVE;
                else
                    state_d = RING_WATCH;
            end
            default: state_d = RING_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= RING_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        ring = 1'b0;
        unique case (state_q)
            RING_ACTIVE: ring = 1'b1;
            RING_OFF,
            RING_WATCH:  ring = 1'b0;
            default:     ring = 1'b0;
        endcase
    end
endmodule

// File: rtl/alarm_time_setter.sv
module alarm_time_setter
    import alarm_time_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_stb,
    input  logic [1:0]        adj_ctl,
    input  logic              arm,
    input  logic [WORD_W-1:0] now_time,
    output logic [WORD_W-1:0] alarm_time,
    output logic              alarm_on
);
    step_cmd_e         cmd;
    logic [WORD_W-1:0] time_q, time_d;
    logic              same_time;

    assign cmd = decode_cmd(step_stb, adj_ctl);

    bcd_minute_stepper i_stepper (
        .cur (time_q),
        .cmd (cmd),
        .nxt (time_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            time_q <= TIME_ZERO;
        else
            time_q <= time_d;
    end

    assign same_time = (now_time == time_q);

    alarm_ring_fsm i_ring (
        .clk   (clk),
        .rst   (rst),
        .arm   (arm),
        .match (same_time),
        .ring  (alarm_on)
    );

    assign alarm_time = time_q;
endmodule

// File: rtl/alarm_time_setter_chk.sv
module alarm_time_setter_chk (
    input logic        clk,
    input logic        rst,
    input logic        step_stb,
    input logic [1:0]  adj_ctl,
    input logic        arm,
    input logic [15:0] now_time,
    input logic [15:0] alarm_time,
    input logic        alarm_on
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (alarm_time == 16'h0000 && !alarm_on));

    // R2
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_time[15:12] <= 4'd2 && alarm_time[11:8] <= 4'd9 &&
         alarm_time[7:4] <= 4'd5 && alarm_time[3:0] <= 4'd9 &&
         alarm_time[15:8] <= 8'h23));

    // R5
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !step_stb |=> $stable(alarm_time));

    // R5
    hold_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        (step_stb && !adj_ctl[1]) |=> $stable(alarm_time));

    // R6
    wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
        (step_stb && adj_ctl == 2'b10 && alarm_time == 16'h2359) |=> alarm_time == 16'h0000);

    // R7
    wrap_down_chk: assert property (@(posedge clk) disable iff (rst)
        (step_stb && adj_ctl == 2'b11 && alarm_time == 16'h0000) |=> alarm_time == 16'h2359);

    // R8
    ring_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        !arm |=> !alarm_on);

    // R8
    ring_match_chk: assert property (@(posedge clk) disable iff (rst)
        (arm && now_time == alarm_time) |=> alarm_on);

    // R8
    ring_mismatch_chk: assert property (@(posedge clk) disable iff (rst)
        (now_time != alarm_time) |=> !alarm_on);
endmodule

bind alarm_time_setter alarm_time_setter_chk i_chk (.*);

// File: tb/test_alarm_time_setter.sv
module test_alarm_time_setter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_stb = 1'b0;
    logic [1:0]  adj_ctl = 2'b00;
    logic        arm = 1'b0;
    logic [15:0] now_time = 16'h0000;
    logic [15:0] alarm_time;
    logic        alarm_on;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_t = 16'h0000;
    logic        exp_on = 1'b0;

    always #10 clk = ~clk;

    alarm_time_setter i_alarm_time_setter (
        .clk(clk), .rst(rst), .step_stb(step_stb), .adj_ctl(adj_ctl),
        .arm(arm), .now_time(now_time), .alarm_time(alarm_time), .alarm_on(alarm_on)
    );

    function automatic int to_min(input logic [15:0] w);
        return (int'(w[15:12]) * 10 + int'(w[11:8])) * 60 + int'(w[7:4]) * 10 + int'(w[3:0]);
    endfunction

    function automatic logic [15:0] to_bcd(input int m);
        int h, mn;
        h  = m / 60;
        mn = m % 60;
        return {4'(h / 10), 4'(h % 10), 4'(mn / 10), 4'(mn % 10)};
    endfunction

    function automatic logic [15:0] model_step(input logic [15:0] t, input logic s, input logic [1:0] a);
        if (s && a == 2'b10) return to_bcd((to_min(t) + 1) % 1440);
        if (s && a == 2'b11) return to_bcd((to_min(t) + 1439) % 1440);
        return t;
    endfunction

    function automatic bit legal(input logic [15:0] w);
        return w[15:12] <= 4'd2 && w[11:8] <= 4'd9 && w[7:4] <= 4'd5 &&
               w[3:0] <= 4'd9 && w[15:8] <= 8'h23;
    endfunction

    task automatic check_val(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Drives one cycle from a falling edge and checks at the next falling edge.
    task automatic cycle(input logic r, input logic s, input logic [1:0] a,
                         input logic ar, input logic [15:0] n, input string req);
        rst = r; step_stb = s; adj_ctl = a; arm = ar; now_time = n;
        if (r) begin
            exp_t = 16'h0000;
            exp_on = 1'b0;
        end else begin
            exp_on = ar && (n == exp_t);
            exp_t = model_step(exp_t, s, a);
        end
        @(posedge clk);
        @(negedge clk);
        check_val(req, alarm_time, exp_t);
        check_val("R8", {15'd0, alarm_on}, {15'd0, exp_on});
    endtask

    task automatic run_steps(input logic [1:0] a, input int n, input string req);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b1, a, 1'b0, 16'h0000, req);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1 reset state
        cycle(1'b1, 1'b0, 2'b00, 1'b0, 16'h0000, "R1");
        cycle(1'b1, 1'b1, 2'b10, 1'b1, 16'h1234, "R1");
        // R7 down-wrap from midnight, R6 up-wrap back
        cycle(1'b0, 1'b1, 2'b11, 1'b0, 16'h0000, "R7");
        check_val("R7", alarm_time, 16'h2359);
        cycle(1'b0, 1'b1, 2'b10, 1'b0, 16'h0000, "R6");
        check_val("R6", alarm_time, 16'h0000);
        // R5 hold cases
        cycle(1'b0, 1'b0, 2'b10, 1'b0, 16'h0000, "R5");
        cycle(1'b0, 1'b1, 2'b00, 1'b0, 16'h0000, "R5");
        cycle(1'b0, 1'b1, 2'b01, 1'b0, 16'h0000, "R5");
        // R3 carries: 00:09->00:10, 00:59->01:00, 09:59->10:00, 19:59->20:00
        run_steps(2'b10, 10, "R3");
        check_val("R3", alarm_time, 16'h0010);
        run_steps(2'b10, 50, "R3");
        check_val("R3", alarm_time, 16'h0100);
        run_steps(2'b10, 540, "R3");
        check_val("R3", alarm_time, 16'h1000);
        run_steps(2'b10, 600, "R3");
        check_val("R3", alarm_time, 16'h2000);
        // R4 borrows back across 20:00 and 10:00
        run_steps(2'b11, 1, "R4");
        check_val("R4", alarm_time, 16'h1959);
        run_steps(2'b11, 600, "R4");
        check_val("R4", alarm_time, 16'h0959);
        // R8 ring on match, off when disarmed or mismatched
        cycle(1'b0, 1'b0, 2'b00, 1'b1, 16'h0959, "R8");
        check_val("R8", {15'd0, alarm_on}, 16'd1);
        cycle(1'b0, 1'b0, 2'b00, 1'b0, 16'h0959, "R8");
        cycle(1'b0, 1'b0, 2'b00, 1'b1, 16'h1000, "R8");
        // Random mix
        for (int k = 0; k < 4000; k++) begin
            logic [1:0] a;
            logic s, ar, r;
            logic [15:0] n;
            s  = ($urandom % 3) != 0;
            a  = 2'($urandom);
            ar = ($urandom % 4) != 0;
            r  = ($urandom % 200) == 0;
            n  = (($urandom % 2) == 0) ? exp_t : to_bcd($urandom % 1440);
            cycle(r, s, a, ar, n, (s && a[1]) ? (a[0] ? "R4" : "R3") : "R5");
            checks++;
            if (!legal(alarm_time)) begin
                errors++;
                $display("FAIL R2 actual=%h expected=legal BCD time", alarm_time);
            end
        end
        finish_run();
    end
endmodule